// File: doc/BRIEF.md
# Spur Transceiver Direction and Enable Controller

This block is glue logic for a multiplexed 16-bit processor bus. One byte lane of that bus reaches a spur of 8-bit peripherals through a bidirectional transceiver. The block sets the transceiver's direction and output enable, and it decodes the chip selects for the peripherals on the spur.

Direction is taken from the processor's data-transmit/receive control. Enable is taken from its data-enable control, and only while the spur is addressed. The read and write strobes never set the direction. The read strobe rises while a peripheral can still be driving its data pins, for up to 15 ns. If the strobe set the direction, the transceiver would turn around into a driven bus.

After any enabled read, a turnaround guard holds the direction at "read" for a set number of clock edges. The direction also cannot change while the transceiver is enabled.

The processor's control outputs float during hold-acknowledge and reset. In that state the block treats data-enable as inactive and transmit/receive as high, and it keeps the transceiver and all chip selects off.

The block has no data path. It therefore has no valid/ready stream interface and no back-pressure. Every pin is a plain level-sensitive control signal, and every output is registered once on `clk`.

Top module: `spur_xcvr_ctrl`

## Requirements
- R1: `xcvr_dir` takes the value of `dtr` (1 = write, processor toward peripherals; 0 = read, peripherals toward processor) on the next clock edge. This happens only while the transceiver is disabled and the turnaround guard has expired.
- R2: `xcvr_oe_n` is low in the cycle after an edge at which all of the following held: `den_n` low, `spur_cs_n` low, `hold_ack` low, and `dtr` equal to the current `xcvr_dir`. Otherwise it is high.
- R3: `xcvr_dir` never changes between two consecutive cycles in which `xcvr_oe_n` is low.
- R4: The enable can drop while the direction is read. In that case `xcvr_dir` stays 0 for that edge and the next `HOLD_CYC` edges (default 2, i.e. 24 ns at 8 ns per cycle). It may change at the earliest on the `HOLD_CYC`+1-th edge after the enable dropped.
- R5: An edge with `hold_ack` high forces `xcvr_oe_n` high and every `per_cs_n` bit high. In that state `dtr` counts as 1 and `den_n` counts as 1.
- R6: While `rst_n` is low: `xcvr_dir` = 1, `xcvr_oe_n` = 1, all `per_cs_n` = 1, and the guard is cleared.
- R7: `per_cs_n[i]` is low in the cycle after an edge at which all of the following held: `spur_cs_n` low, `hold_ack` low, at least one of `rd_n`/`wr_n`/`den_n` low, and the field `addr[SEL_LSB +: SEL_W]` equal to i. At most one bit is ever low.
- R8: `rd_n` and `wr_n` have no effect on `xcvr_dir` or `xcvr_oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_ack | input | 1 | Processor has granted the bus; its controls float |
| dtr | input | 1 | Processor transmit/receive control, 1 = write |
| den_n | input | 1 | Processor data enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| spur_cs_n | input | 1 | Upstream decode: the access targets the spur, active low |
| addr | input | ADDR_W | Latched address |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward peripherals |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |
| per_cs_n | output | NPER | Peripheral chip selects, active low |

## Verification
Each of `xcvr_dir`, `xcvr_oe_n` and `per_cs_n` is due one clock edge after the inputs that cause it. The only exception is the read turnaround, whose direction change is due `HOLD_CYC`+1 edges after the enable drops.

The bench drives inputs at the falling edge. It steps its own reference model across the following rising edge and compares all outputs at the next falling edge, so each comparison sits exactly one register stage after its stimulus. The directed turnaround case counts falling edges after the enable drops and expects read on each of the first `HOLD_CYC`+1 and write on the one after.

// File: rtl/spur_pkg.sv
package spur_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } xdir_e;

  // Controls after forcing the floating-input cases to their inactive level.
  typedef struct packed {
    logic hold;    // bus granted away
    logic dtr;     // direction request, 1 = write
    logic den;     // data enable, active high
    logic spur;    // spur addressed
    logic access;  // any strobe or enable active
  } ctl_s;
endpackage

// File: rtl/spur_ctl_sanitize.sv
module spur_ctl_sanitize
  import spur_pkg::*;
(
  input  logic hold_ack,
  input  logic dtr,
  input  logic den_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic spur_cs_n,
  output ctl_s ctl
);
  always_comb begin
    ctl.hold   = hold_ack;
    // Floating controls read as pulled up: dtr high, enables inactive.
    ctl.dtr    = hold_ack | dtr;
    ctl.den    = ~hold_ack & ~den_n;
    ctl.spur   = ~hold_ack & ~spur_cs_n;
    ctl.access = ~hold_ack & (~rd_n | ~wr_n | ~den_n);
  end
endmodule

// File: rtl/spur_addr_decode.sv
module spur_addr_decode
  import spur_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NPER    = 2,
  parameter int SEL_LSB = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_s              ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic [NPER-1:0]   per_cs_n
);
  localparam int SEL_W = (NPER > 1) ? $clog2(NPER) : 1;

  logic [SEL_W-1:0] sel_field;
  logic             hit;

  assign sel_field = addr[SEL_LSB +: SEL_W];
  assign hit       = ctl.spur & ctl.access;

  for (genvar g = 0; g < NPER; g++) begin : g_cs
    logic cs_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q <= 1'b0;
      else        cs_q <= hit && (sel_field == SEL_W'(g));
    end
    assign per_cs_n[g] = ~cs_q;
  end

  AST_CS_ONE_AT_MOST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~per_cs_n)) else $error("chip select overlap"); // R7

  AST_CS_OFF_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.hold |=> (&per_cs_n)) else $error("chip select during hold"); // R5
endmodule

// File: rtl/spur_dir_guard.sv
module spur_dir_guard
  import spur_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  ctl_s ctl,
  output logic xcvr_dir,
  output logic xcvr_oe_n
);
  localparam int GW = $clog2(HOLD_CYC + 1);

  xdir_e         dir_q;
  logic          oe_q;
  logic          oe_nx;
  logic [GW-1:0] guard_q;

  // Enable only when the request matches the direction already set.
  assign oe_nx = ctl.den & ctl.spur & (xdir_e'(ctl.dtr) == dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_WR;
      oe_q    <= 1'b0;
      guard_q <= '0;
    end else begin
      oe_q <= oe_nx;
      if (!oe_q && guard_q == '0)
        dir_q <= xdir_e'(ctl.dtr);
      if (oe_q && !oe_nx && dir_q == DIR_RD)
        guard_q <= GW'(HOLD_CYC);
      else if (oe_nx)
        guard_q <= '0;
      else if (guard_q != '0)
        guard_q <= guard_q - 1'b1;
    end
  end

  assign xcvr_dir  = dir_q;
  assign xcvr_oe_n = ~oe_q;

  AST_DIR_FROZEN_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q)) |-> (dir_q == $past(dir_q))) else $error("direction moved while enabled"); // R3

  AST_GUARD_HOLDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_q != '0) |=> (dir_q == $past(dir_q))) else $error("direction moved in turnaround"); // R4

  AST_GUARD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !oe_nx && dir_q == DIR_RD) |=> (guard_q != '0)) else $error("turnaround not armed"); // R4
endmodule

// File: rtl/spur_xcvr_ctrl.sv
module spur_xcvr_ctrl
  import spur_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NPER     = 2,
  parameter int SEL_LSB  = 1,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_ack,
  input  logic              dtr,
  input  logic              den_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              spur_cs_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              xcvr_dir,
  output logic              xcvr_oe_n,
  output logic [NPER-1:0]   per_cs_n
);
  ctl_s ctl;

  spur_ctl_sanitize i_sanitize (
    .hold_ack  (hold_ack),
    .dtr       (dtr),
    .den_n     (den_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .spur_cs_n (spur_cs_n),
    .ctl       (ctl)
  );

  spur_dir_guard #(.HOLD_CYC(HOLD_CYC)) i_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .xcvr_dir  (xcvr_dir),
    .xcvr_oe_n (xcvr_oe_n)
  );

  spur_addr_decode #(.ADDR_W(ADDR_W), .NPER(NPER), .SEL_LSB(SEL_LSB)) i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .addr     (addr),
    .per_cs_n (per_cs_n)
  );

  AST_OE_NEEDS_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_oe_n |-> $past(!den_n && !spur_cs_n && !hold_ack)) else $error("enable without request"); // R2

  AST_HOLD_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |=> xcvr_oe_n) else $error("enabled during hold"); // R5
endmodule

// File: tb/test_spur_xcvr_ctrl.sv
module test_spur_xcvr_ctrl;
  localparam int ADDR_W = 8, NPER = 2, SEL_LSB = 1, HOLD_CYC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_ack = 0, dtr = 1, den_n = 1, rd_n = 1, wr_n = 1, spur_cs_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic xcvr_dir, xcvr_oe_n;
  logic [NPER-1:0] per_cs_n;

  int total = 0, bad = 0;
  logic m_dir = 1, m_oe = 0;
  int   m_guard = 0;
  logic [NPER-1:0] m_cs_n = '1;

  always #4 clk = ~clk;

  spur_xcvr_ctrl #(.ADDR_W(ADDR_W), .NPER(NPER), .SEL_LSB(SEL_LSB), .HOLD_CYC(HOLD_CYC))
    i_spur_xcvr_ctrl (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model from the requirements: next state after one edge.
  task automatic model_edge();
    logic dtr_e, den_e, spur_e, acc_e, oe_nx;
    dtr_e  = hold_ack | dtr;
    den_e  = !hold_ack && !den_n;
    spur_e = !hold_ack && !spur_cs_n;
    acc_e  = !hold_ack && (!rd_n || !wr_n || !den_n);
    oe_nx  = den_e && spur_e && (dtr_e == m_dir);
    for (int i = 0; i < NPER; i++)
      m_cs_n[i] = !(spur_e && acc_e && (int'(addr[SEL_LSB +: 1]) == i));
    if (m_oe && !oe_nx && m_dir == 1'b0) m_guard = HOLD_CYC;
    else if (oe_nx) m_guard = 0;
    else if (m_guard != 0) m_guard = m_guard - 1;
    if (!m_oe && (m_guard == HOLD_CYC ? 1'b0 : 1'b1) && m_guard_prev_zero) m_dir = dtr_e;
    m_oe = oe_nx;
  endtask

  // Guard value before the edge decides whether dir may update.
  logic m_guard_prev_zero;

  logic prev_oe_on = 0, prev_dir = 1;
  task automatic step();
    m_guard_prev_zero = (m_guard == 0);
    begin
      logic oe_was = m_oe;
      model_edge();
      if (!oe_was && m_guard_prev_zero) ; // dir already updated in model_edge
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1/R4 dir", {7'd0, xcvr_dir}, {7'd0, m_dir});
    chk("R2/R5 oe_n", {7'd0, xcvr_oe_n}, {7'd0, !m_oe});
    chk("R7 cs_n", 8'(per_cs_n), 8'(m_cs_n));
    // contention watch: direction change while enabled in both cycles
    if (!xcvr_oe_n && prev_oe_on) chk("R3 dir stable while on", {7'd0, xcvr_dir}, {7'd0, prev_dir});
    prev_oe_on = !xcvr_oe_n;
    prev_dir   = xcvr_dir;
  endtask

  task automatic drive(logic h, logic t, logic de, logic r, logic w, logic s, logic [ADDR_W-1:0] a);
    hold_ack = h; dtr = t; den_n = de; rd_n = r; wr_n = w; spur_cs_n = s; addr = a;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    @(negedge clk); @(negedge clk);
    // R6 reset state
    chk("R6 dir", {7'd0, xcvr_dir}, 8'd1);
    chk("R6 oe_n", {7'd0, xcvr_oe_n}, 8'd1);
    chk("R6 cs_n", 8'(per_cs_n), 8'(2'b11));
    rst_n = 1;

    // Read to peripheral 1: dir goes to read, then enable.
    drive(0, 0, 1, 1, 1, 0, 8'h02); step();
    chk("R1 dir to read", {7'd0, xcvr_dir}, 8'd0);
    drive(0, 0, 0, 0, 1, 0, 8'h02); step();
    chk("R2 oe on for read", {7'd0, xcvr_oe_n}, 8'd0);
    chk("R7 cs1 low", 8'(per_cs_n), 8'(2'b01));
    // R8: rd_n rises, den still low: nothing changes
    drive(0, 0, 0, 1, 1, 0, 8'h02); step();
    chk("R8 rd_n no effect oe", {7'd0, xcvr_oe_n}, 8'd0);
    chk("R8 rd_n no effect dir", {7'd0, xcvr_dir}, 8'd0);
    // R4: end read, request write immediately
    drive(0, 1, 1, 1, 1, 1, 8'h00); step();
    chk("R4 held edge0", {7'd0, xcvr_dir}, 8'd0);
    for (int k = 0; k < HOLD_CYC; k++) begin
      step();
      chk("R4 held in guard", {7'd0, xcvr_dir}, 8'd0);
    end
    step();
    chk("R4 released to write", {7'd0, xcvr_dir}, 8'd1);

    // R5: hold forces everything off and dtr reads as 1
    drive(1, 0, 0, 0, 0, 0, 8'h00); step();
    chk("R5 oe off in hold", {7'd0, xcvr_oe_n}, 8'd1);
    chk("R5 cs off in hold", 8'(per_cs_n), 8'(2'b11));
    chk("R5 dtr as write", {7'd0, xcvr_dir}, 8'd1);

    // R8: toggling wr_n/rd_n with no enable leaves dir and oe alone
    drive(0, 1, 1, 0, 0, 1, 8'h00); step();
    chk("R8 strobes no effect", {6'd0, xcvr_dir, xcvr_oe_n}, 8'd3);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      drive(r[3:0] == 0, (r[6:4] != 0) ? dtr : r[7], r[8] & r[9], r[10], r[11], r[12] & r[13] & r[14],
            8'(r[23:16]));
      step();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule